// File: doc/BRIEF.md
# Fixed-Service DRAM Command Scheduler

This block issues DRAM commands on behalf of several mutually distrusting security domains so that the command stream each domain can observe is the same whatever the others do. Time is cut into slots of a fixed length. The domains own the slots in strict rotation, and one turn through all of them forms a quantum. At the first cycle of its slot, the owning domain's head request is taken. Its activate and column commands are then placed at fixed offsets from that cycle. A domain with nothing to send still gets its slot, filled with a dummy read that has exactly the timing of a real one.

The slot length follows a partitioning mode that is sampled only when a quantum begins. Per-domain completions are collected and released as one pulse per quantum, two quanta after the requests were taken. A sticky flag reports any case where two commands would need the same command-bus cycle. That can only happen with slot lengths outside the allowed set.

Requests enter on a valid/ready pair per domain. `req_ready[d]` is high only in the single cycle in which domain d's slot decision is made. A request held valid waits there, without loss, until its domain's next slot. There is no other back-pressure. The command outputs carry no ready: each command must leave in its fixed cycle, so the consumer has to accept every cycle.

Top module: `fs_sched`

## Requirements
- R1: Domains own slots in rotation 0,1,2,3,0,… starting with domain 0 at the first clock edge after reset. `req_ready` has at most one bit set, only domain d's bit is set, and it is set only in the cycle before domain d's slot-start edge. A request is taken when valid and ready are both high at that edge.
- R2: The slot length L is set by `mode_sel`: 0 rank split (7 cycles), 1 bank split (15), 2 shared (43), 3 shared with three-group rotation (15). A quantum lasts 4·L.
- R3: For a read taken at slot-start edge e, an ACT appears after edge e and the RD after edge e+tRCD (tRCD=11). Its data therefore starts tCAS+tRCD=22 cycles after e.
- R4: For a write taken at edge e, the ACT appears after edge e+(tCAS−tCWD)=e+6 and the WR after edge e+17. Its data therefore also starts 22 cycles after e.
- R5: If the slot owner has no valid request, a dummy read is issued with read timing, `cmd_dummy`=1, address 0 and the owner's index in `cmd_dom`. Dummies are never writes.
- R6: `cmd_kind` encodes 0 idle, 1 ACT, 2 RD, 3 WR. A real command carries the request's address and domain with `cmd_dummy`=0. Idle cycles drive every command field to 0.
- R7: `done_mask` is high for exactly one cycle, after each quantum-start edge. Bit d is set iff domain d had a request taken in the quantum that began two quanta earlier. The mask is 0 in every other cycle.
- R8: `mode_sel` is sampled only at quantum-start edges. A change in mid-quantum leaves the running quantum's slot length unchanged.
- R9: In mode 3, `cmd_grp` on a command carries the index of its slot counted since reset, modulo 3. In all other modes it is 0.
- R10: `clash_err` rises and stays high if a new command would need a cycle already taken. With the default parameters it never rises in any mode or traffic mix. With a 6-cycle rank-mode slot, a write among reads sets it.
- R11: During reset `cmd_kind`, `done_mask` and `clash_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Partitioning mode, sampled at quantum start |
| req_valid | input | N_DOM | Per-domain request valid |
| req_ready | output | N_DOM | Per-domain request ready (slot decision cycle) |
| req_we | input | N_DOM | Per-domain request is a write |
| req_addr | input | N_DOM*ADDR_W | Per-domain request address, domain d at bits d*ADDR_W |
| cmd_kind | output | 2 | Command type: 0 idle, 1 ACT, 2 RD, 3 WR |
| cmd_dom | output | DOM_W | Domain that owns the command |
| cmd_addr | output | ADDR_W | Command address |
| cmd_dummy | output | 1 | Command belongs to a dummy fill |
| cmd_grp | output | 2 | Bank group in rotation mode |
| done_mask | output | N_DOM | Per-domain completion pulse at quantum start |
| clash_err | output | 1 | Sticky command-bus collision flag |

## Verification
The command stream is compared cycle by cycle against a schedule built in the bench under several traffic patterns. All-idle traffic shows that dummy fills keep the slot grid. Mixed read/write traffic shows that the ACT/CAS offsets depend on direction but not on the other domains. All-write and partly-idle patterns in the wider modes separate the slot lengths and the group rotation. A mid-quantum mode change tells sampling at the boundary apart from sampling at once. A second instance with a 6-cycle slot shows that the collision flag stays low for a read-only mix and rises when a write joins.

// File: rtl/fs_sched_pkg.sv
package fs_sched_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'd0,
    CMD_ACT = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_kind_e;

  typedef enum logic [1:0] {
    MODE_RANK   = 2'd0,
    MODE_BANK   = 2'd1,
    MODE_SHARED = 2'd2,
    MODE_TRIPLE = 2'd3
  } part_mode_e;
endpackage

// File: rtl/fs_slot_timer.sv
module fs_slot_timer #(
  parameter int N_DOM    = 4,
  parameter int DOM_W    = 2,
  parameter int CNT_W    = 6,
  parameter int L_RANK   = 7,
  parameter int L_BANK   = 15,
  parameter int L_SHARED = 43,
  parameter int L_TRIPLE = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_sel,
  output logic             slot_start,
  output logic             q_start,
  output logic [DOM_W-1:0] slot_dom,
  output logic [1:0]       slot_grp
);
  import fs_sched_pkg::*;

  logic [CNT_W-1:0] cnt;
  logic [DOM_W-1:0] sidx;
  logic [1:0]       g3;
  logic [1:0]       mode_q;
  logic [1:0]       eff_mode;

  function automatic logic [CNT_W-1:0] last_cnt(input logic [1:0] m);
    int len;
    case (part_mode_e'(m))
      MODE_RANK:   len = L_RANK;
      MODE_BANK:   len = L_BANK;
      MODE_SHARED: len = L_SHARED;
      default:     len = L_TRIPLE;
    endcase
    return CNT_W'(len - 1);
  endfunction

  assign slot_start = (cnt == '0);
  assign q_start    = slot_start && (sidx == '0);
  assign slot_dom   = sidx;
  assign eff_mode   = q_start ? mode_sel : mode_q;
  assign slot_grp   = (part_mode_e'(eff_mode) == MODE_TRIPLE) ? g3 : 2'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      sidx   <= '0;
      g3     <= 2'd0;
      mode_q <= mode_sel;
    end else begin
      if (q_start) mode_q <= mode_sel;
      if (cnt == last_cnt(mode_q)) begin
        cnt  <= '0;
        sidx <= (sidx == DOM_W'(N_DOM - 1)) ? '0 : sidx + 1'b1;
        g3   <= (g3 == 2'd2) ? 2'd0 : g3 + 2'd1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fs_cmd_pipe.sv
module fs_cmd_pipe #(
  parameter int DEPTH = 22,
  parameter int EW    = 24,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ins_en,
  input  logic [IDX_W-1:0] act_idx,
  input  logic [EW-1:0]    act_ent,
  input  logic [IDX_W-1:0] cas_idx,
  input  logic [EW-1:0]    cas_ent,
  output logic [EW-1:0]    head,
  output logic             clash
);
  logic [EW-1:0] pipe    [DEPTH];
  logic [EW-1:0] shifted [DEPTH];
  logic [EW-1:0] nxt     [DEPTH];
  logic          hit;

  for (genvar i = 0; i < DEPTH; i++) begin : g_shift
    if (i < DEPTH - 1) begin : g_mid
      assign shifted[i] = pipe[i+1];
    end else begin : g_top
      assign shifted[i] = '0;
    end
  end

  always_comb begin
    nxt = shifted;
    hit = 1'b0;
    if (ins_en) begin
      if (nxt[act_idx][EW-1]) hit = 1'b1;
      else                    nxt[act_idx] = act_ent;
      if (nxt[cas_idx][EW-1]) hit = 1'b1;
      else                    nxt[cas_idx] = cas_ent;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) pipe[i] <= '0;
      clash <= 1'b0;
    end else begin
      pipe <= nxt;
      if (hit) clash <= 1'b1;
    end
  end

  assign head = pipe[0];
endmodule

// File: rtl/fs_done_gather.sv
module fs_done_gather #(
  parameter int N_DOM = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_start,
  input  logic [N_DOM-1:0] taken,
  output logic [N_DOM-1:0] done_mask
);
  logic [N_DOM-1:0] cur_set;
  logic [N_DOM-1:0] prev_set;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_set   <= '0;
      prev_set  <= '0;
      done_mask <= '0;
    end else if (q_start) begin
      done_mask <= prev_set;
      prev_set  <= cur_set;
      cur_set   <= taken;
    end else begin
      done_mask <= '0;
      cur_set   <= cur_set | taken;
    end
  end
endmodule

// File: rtl/fs_sched.sv
module fs_sched #(
  parameter int N_DOM    = 4,
  parameter int ADDR_W   = 16,
  parameter int T_CAS    = 11,
  parameter int T_CWD    = 5,
  parameter int T_RCD    = 11,
  parameter int L_RANK   = 7,
  parameter int L_BANK   = 15,
  parameter int L_SHARED = 43,
  parameter int L_TRIPLE = 15,
  localparam int DOM_W   = (N_DOM > 1) ? $clog2(N_DOM) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [1:0]              mode_sel,
  input  logic [N_DOM-1:0]        req_valid,
  output logic [N_DOM-1:0]        req_ready,
  input  logic [N_DOM-1:0]        req_we,
  input  logic [N_DOM*ADDR_W-1:0] req_addr,
  output logic [1:0]              cmd_kind,
  output logic [DOM_W-1:0]        cmd_dom,
  output logic [ADDR_W-1:0]       cmd_addr,
  output logic                    cmd_dummy,
  output logic [1:0]              cmd_grp,
  output logic [N_DOM-1:0]        done_mask,
  output logic                    clash_err
);
  import fs_sched_pkg::*;

  localparam int L_MAX1 = (L_RANK > L_BANK) ? L_RANK : L_BANK;
  localparam int L_MAX2 = (L_SHARED > L_TRIPLE) ? L_SHARED : L_TRIPLE;
  localparam int L_MAX  = (L_MAX1 > L_MAX2) ? L_MAX1 : L_MAX2;
  localparam int CNT_W  = $clog2(L_MAX + 1);
  localparam int DEPTH  = T_CAS + T_RCD;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int W_OFF  = T_CAS - T_CWD;
  localparam int EW     = 1 + 2 + DOM_W + ADDR_W + 1 + 2;

  logic             slot_start, q_start;
  logic [DOM_W-1:0] slot_dom;
  logic [1:0]       slot_grp;
  logic             own_valid, own_we, real_op, is_wr;
  logic [ADDR_W-1:0] own_addr, use_addr;
  logic [IDX_W-1:0] act_idx, cas_idx;
  logic [EW-1:0]    act_ent, cas_ent, head;
  logic             head_v;
  logic [1:0]       head_kind;

  fs_slot_timer #(
    .N_DOM(N_DOM), .DOM_W(DOM_W), .CNT_W(CNT_W),
    .L_RANK(L_RANK), .L_BANK(L_BANK), .L_SHARED(L_SHARED), .L_TRIPLE(L_TRIPLE)
  ) u_timer (
    .clk(clk), .rst(rst), .mode_sel(mode_sel),
    .slot_start(slot_start), .q_start(q_start),
    .slot_dom(slot_dom), .slot_grp(slot_grp)
  );

  for (genvar d = 0; d < N_DOM; d++) begin : g_ready
    assign req_ready[d] = slot_start && (slot_dom == DOM_W'(d));
  end

  assign own_valid = req_valid[slot_dom];
  assign own_we    = req_we[slot_dom];
  assign own_addr  = req_addr[slot_dom*ADDR_W +: ADDR_W];
  assign real_op   = own_valid;
  assign is_wr     = real_op && own_we;
  assign use_addr  = real_op ? own_addr : '0;

  assign act_idx = is_wr ? IDX_W'(W_OFF) : '0;
  assign cas_idx = act_idx + IDX_W'(T_RCD);
  assign act_ent = {1'b1, CMD_ACT, slot_dom, use_addr, ~real_op, slot_grp};
  assign cas_ent = {1'b1, (is_wr ? CMD_WR : CMD_RD), slot_dom, use_addr, ~real_op, slot_grp};

  fs_cmd_pipe #(.DEPTH(DEPTH), .EW(EW), .IDX_W(IDX_W)) u_pipe (
    .clk(clk), .rst(rst), .ins_en(slot_start),
    .act_idx(act_idx), .act_ent(act_ent),
    .cas_idx(cas_idx), .cas_ent(cas_ent),
    .head(head), .clash(clash_err)
  );

  assign {head_v, head_kind, cmd_dom, cmd_addr, cmd_dummy, cmd_grp} = head;
  assign cmd_kind = head_v ? head_kind : CMD_NOP;

  fs_done_gather #(.N_DOM(N_DOM)) u_done (
    .clk(clk), .rst(rst), .q_start(q_start),
    .taken(req_valid & req_ready), .done_mask(done_mask)
  );
endmodule

// File: rtl/fs_sched_chk.sv
module fs_sched_chk #(
  parameter int N_DOM = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_DOM-1:0] req_ready,
  input logic [N_DOM-1:0] done_mask,
  input logic             clash_err,
  input logic [1:0]       cmd_kind,
  input logic             cmd_dummy
);
  // R1
  ready_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready));

  // R1
  ready_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_ready != '0) |=> (req_ready == '0));

  // R7
  done_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (done_mask != '0) |=> (done_mask == '0));

  // R10
  clash_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    clash_err |=> clash_err);

  // R5
  dummy_never_write_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_dummy |-> (cmd_kind != 2'd3));
endmodule

bind fs_sched fs_sched_chk #(.N_DOM(N_DOM)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .done_mask(done_mask),
  .clash_err(clash_err), .cmd_kind(cmd_kind), .cmd_dummy(cmd_dummy)
);

// File: tb/fs_sched_tb.sv
`timescale 1ns/1ps
module fs_sched_tb;
  localparam int N   = 4;
  localparam int AW  = 16;
  localparam int NC  = 1024;
  localparam int RCD = 11;
  localparam int WOF = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0]      mode_sel = 2'd0;
  logic [N-1:0]    req_valid = '0, req_we = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N-1:0]    req_ready, done_mask, req_ready6, done_mask6;
  logic [1:0]      cmd_kind, cmd_grp, cmd_kind6, cmd_grp6;
  logic [1:0]      cmd_dom, cmd_dom6;
  logic [AW-1:0]   cmd_addr, cmd_addr6;
  logic            cmd_dummy, clash_err, cmd_dummy6, clash_err6;

  int checks = 0, fails = 0, edges = 0;

  logic [1:0]    ek  [NC];
  logic [1:0]    ed  [NC];
  logic [AW-1:0] ea  [NC];
  logic          edm [NC];
  logic [1:0]    eg  [NC];
  logic [N-1:0]  er  [NC];
  logic [N-1:0]  edn [NC];

  always #5 clk = ~clk;
  always @(posedge clk) edges <= rst ? 0 : edges + 1;

  fs_sched u_dut (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_we(req_we), .req_addr(req_addr),
    .cmd_kind(cmd_kind), .cmd_dom(cmd_dom), .cmd_addr(cmd_addr),
    .cmd_dummy(cmd_dummy), .cmd_grp(cmd_grp), .done_mask(done_mask),
    .clash_err(clash_err)
  );

  fs_sched #(.L_RANK(6)) u_dut_l6 (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .req_valid(req_valid),
    .req_ready(req_ready6), .req_we(req_we), .req_addr(req_addr),
    .cmd_kind(cmd_kind6), .cmd_dom(cmd_dom6), .cmd_addr(cmd_addr6),
    .cmd_dummy(cmd_dummy6), .cmd_grp(cmd_grp6), .done_mask(done_mask6),
    .clash_err(clash_err6)
  );

  function automatic int len_of(input int m);
    case (m)
      0: return 7;
      1: return 15;
      2: return 43;
      default: return 15;
    endcase
  endfunction

  function automatic logic [AW-1:0] dom_addr(input int d);
    return AW'(16'hA000 + d * 16'h0111);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input int m);
    rst = 1'b1;
    mode_sel = 2'(m);
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_traffic(input logic [N-1:0] vm, input logic [N-1:0] wm);
    req_valid = vm;
    req_we    = wm;
    for (int d = 0; d < N; d++) req_addr[d*AW +: AW] = dom_addr(d);
  endtask

  task automatic put(input int t, input logic [1:0] k, input int d,
                     input logic [AW-1:0] a, input logic dm, input logic [1:0] g);
    if (t < NC) begin
      ek[t] = k; ed[t] = 2'(d); ea[t] = a; edm[t] = dm; eg[t] = g;
    end
  endtask

  // Expected schedule from R1..R9
  task automatic build(input int ma, input int mb, input int sw,
                       input logic [N-1:0] vm, input logic [N-1:0] wm);
    int t, n, qi, m, l, b;
    logic rl, wr;
    logic [1:0] g;
    for (int i = 0; i < NC; i++) begin
      ek[i] = 0; ed[i] = 0; ea[i] = 0; edm[i] = 0; eg[i] = 0; er[i] = 0; edn[i] = 0;
    end
    t = 0; n = 0; qi = 0;
    while (t < NC) begin
      m = (t >= sw) ? mb : ma;
      l = len_of(m);
      if (qi >= 2) edn[t] = vm;
      for (int s = 0; s < N; s++) begin
        b  = t + s * l;
        rl = vm[s];
        wr = rl & wm[s];
        g  = (m == 3) ? 2'(n % 3) : 2'd0;
        if (b < NC) er[b][s] = 1'b1;
        put(b + (wr ? WOF : 0), 2'd1, s, rl ? dom_addr(s) : '0, ~rl, g);
        put(b + (wr ? WOF : 0) + RCD, wr ? 2'd3 : 2'd2, s, rl ? dom_addr(s) : '0, ~rl, g);
        n++;
      end
      t += N * l;
      qi++;
    end
  endtask

  task automatic run_cmp(input int len, input int mb, input int sw, input string lbl);
    int ec, er_n, ed_n, fc, fr, fd, ac, xc;
    ec = 0; er_n = 0; ed_n = 0; fc = -1; fr = -1; fd = -1; ac = 0; xc = 0;
    for (int e = 0; e < len; e++) begin
      @(negedge clk);
      if (cmd_kind != ek[e] || cmd_dom != ed[e] || cmd_addr != ea[e] ||
          cmd_dummy != edm[e] || cmd_grp != eg[e]) begin
        if (ec == 0) begin fc = e; ac = {cmd_kind, cmd_dom, cmd_grp}; xc = {ek[e], ed[e], eg[e]}; end
        ec++;
      end
      if (req_ready != er[e+1]) begin
        if (er_n == 0) fr = e;
        er_n++;
      end
      if (done_mask != edn[e]) begin
        if (ed_n == 0) fd = e;
        ed_n++;
      end
      if (e + 1 == sw) mode_sel = 2'(mb);
    end
    if (ec != 0) $display("  %s: first command mismatch at cycle %0d", lbl, fc);
    check(ec == 0, "R2 R3 R4 R5 R6", {lbl, " command stream (kind,dom,grp packed)"}, ac, xc);
    if (er_n != 0) $display("  %s: first ready mismatch at cycle %0d", lbl, fr);
    check(er_n == 0, "R1", {lbl, " ready pattern mismatches"}, er_n, 0);
    if (ed_n != 0) $display("  %s: first completion mismatch at cycle %0d", lbl, fd);
    check(ed_n == 0, "R7", {lbl, " completion mismatches"}, ed_n, 0);
    check(clash_err == 1'b0, "R10", {lbl, " clash flag at default slot lengths"}, clash_err, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    set_traffic('1, '1);
    repeat (3) @(negedge clk);
    // R11
    check(cmd_kind == 2'd0, "R11", "command kind in reset", cmd_kind, 0);
    check(done_mask == '0, "R11", "completion mask in reset", done_mask, 0);
    check(clash_err == 1'b0, "R11", "clash flag in reset", clash_err, 0);
  endtask

  task automatic t_pattern(input int m, input logic [N-1:0] vm, input logic [N-1:0] wm,
                           input int len, input string lbl);
    set_traffic(vm, wm);
    build(m, m, NC + 1, vm, wm);
    do_reset(m);
    run_cmp(len, m, NC + 1, lbl);
  endtask

  // R8: mode changes mid-quantum, must take effect at the next quantum only
  task automatic t_mode_switch;
    set_traffic(4'b1011, 4'b0010);
    build(0, 1, 40, 4'b1011, 4'b0010);
    do_reset(0);
    run_cmp(300, 1, 40, "R8 mode switch");
  endtask

  // R10: six-cycle rank slots
  task automatic t_clash;
    set_traffic(4'b1111, 4'b0000);
    do_reset(0);
    repeat (150) @(negedge clk);
    check(clash_err6 == 1'b0, "R10", "L=6 read-only clash flag", clash_err6, 0);
    set_traffic(4'b1111, 4'b0010);
    do_reset(0);
    repeat (150) @(negedge clk);
    check(clash_err6 == 1'b1, "R10", "L=6 with a write clash flag", clash_err6, 1);
    check(clash_err == 1'b0, "R10", "L=7 with a write clash flag", clash_err, 0);
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_pattern(0, 4'b0000, 4'b0000, 200, "R5 rank idle");
    t_pattern(0, 4'b1111, 4'b0101, 200, "R3 R4 rank mixed");
    t_pattern(1, 4'b1111, 4'b1111, 300, "R4 bank writes");
    t_pattern(2, 4'b0110, 4'b0100, 570, "R2 shared partial");
    t_pattern(3, 4'b1101, 4'b1000, 300, "R9 triple rotation");
    t_mode_switch();
    t_clash();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule